// File: doc/BRIEF.md
# Radio Packet Transmit Framer

This block assembles one outgoing radio packet per request and hands it, byte by byte, to a downstream byte sink over a valid/ready handshake. Each packet opens with three 0xAA training bytes and the sync pair 0x2D followed by the network group value. Next come a header byte, a length byte, the payload and a two-byte checksum. A single 0xAA pad byte closes the packet.

The payload comes from one of two places. In buffer mode a host first fills an internal byte store through a simple write port, then issues a request with a length. In stream mode the request opens a capture window: beats are taken from a streaming input until the beat carrying the last flag, and the count of captured beats becomes the length field. The length byte must precede the payload, so a streamed payload is stored completely before transmission begins. The checksum is a reflected CRC-16 (polynomial 0xA001, seeded with 0xFFFF) taken over group, header, length and payload.

Top module: `pkt_tx_framer`

## Requirements
- R1: An accepted request emits, in this order: 0xAA three times, 0x2D, the group, the header, the length byte, the payload bytes, the checksum low byte, the checksum high byte, and one 0xAA pad byte.
- R2: The checksum starts at 0xFFFF and absorbs group, header, length and each payload byte in that order; each byte is XORed into the low end, then eight shifts right with 0xA001 applied whenever the bit shifted out is 1.
- R3: With src_buf=1, the payload is the cfg_len bytes at buffer addresses 0 to cfg_len-1, in address order, as written beforehand through bw_en/bw_addr/bw_data.
- R4: With src_buf=0, s_ready rises after the request and the block accepts beats until the beat with s_last=1; the length field equals the number of beats taken. Capture also stops after 255 beats without a last flag, after which s_ready is low and further beats are not taken.
- R5: A buffer-mode request with cfg_len=0 emits no byte, raises no done pulse and leaves busy low.
- R6: done is high for exactly one cycle, in the cycle after the pad byte is accepted.
- R7: While m_valid is high and m_ready is low, m_valid stays high and m_data does not change.
- R8: Group and header are captured when the request is taken; changes to cfg_group or cfg_header afterwards do not alter the packet in flight.
- R9: In buffer mode with m_ready held high, m_valid first rises one clock edge after the edge that samples start, and a packet of length L produces done in the cycle after edge L+11 counted from that sampling edge (edge 0).
- R10: A start pulse while busy is high is ignored: the packet in flight is unchanged and only one done pulse results.
- R11: During and right after reset, m_valid, s_ready, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only when idle |
| src_buf | input | 1 | Payload source: 1 buffer, 0 stream |
| cfg_group | input | 8 | Network group value |
| cfg_header | input | 8 | Header byte |
| cfg_len | input | 8 | Payload length for buffer mode |
| bw_en | input | 1 | Buffer write enable |
| bw_addr | input | ADDR_W | Buffer write address |
| bw_data | input | 8 | Buffer write data |
| s_data | input | 8 | Stream payload byte |
| s_valid | input | 1 | Stream beat valid |
| s_last | input | 1 | Stream beat is the final payload byte |
| s_ready | output | 1 | Stream capture window open |
| m_data | output | 8 | Outgoing packet byte |
| m_valid | output | 1 | Outgoing byte valid |
| m_ready | input | 1 | Sink accepts the byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The first byte is due one edge after the edge that samples start, each later byte one edge after the previous handshake, and done one edge after the pad byte's handshake; with a continuously ready sink that places done after edge L+11. The bench drives inputs and the sink's ready one time unit after the rising edge and reads every output at the falling edge, so each handshake it records is the one the next rising edge completes. Packets are compared as whole byte sequences against a frame and checksum built inside the bench, which keeps the comparisons independent of how many stall cycles the ready pattern inserts.

// File: rtl/pkt_frm_pkg.sv
package pkt_frm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CAPT,
    ST_PRE,
    ST_SYNC,
    ST_GRP,
    ST_HDR,
    ST_LEN,
    ST_PAY,
    ST_CRCL,
    ST_CRCH,
    ST_PAD,
    ST_DRAIN
  } frm_state_e;

  // One byte through a reflected CRC-16, least significant bit first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                             input logic [7:0]  din,
                                             input logic [15:0] poly);
    logic [15:0] c;
    c = crc_in ^ {8'h00, din};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/pkt_crc16.sv
module pkt_crc16 #(
  parameter logic [15:0] POLY = 16'hA001,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import pkt_frm_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc <= INIT;
    end else if (en) begin
      crc <= crc16_byte(crc, din, POLY);
    end
  end

endmodule

// File: rtl/pkt_payload_buf.sv
module pkt_payload_buf #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single clock, registered read: maps onto a simple dual-port RAM.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pkt_frame_seq.sv
module pkt_frame_seq
  import pkt_frm_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         MAX_LEN   = 255,
  parameter int         PRE_COUNT = 3,
  parameter logic [7:0] PRE_BYTE  = 8'hAA,
  parameter logic [7:0] SYNC_BYTE = 8'h2D,
  parameter logic [7:0] PAD_BYTE  = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              src_buf,
  input  logic [7:0]        cfg_group,
  input  logic [7:0]        cfg_header,
  input  logic [7:0]        cfg_len,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              cap_we,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  input  logic [15:0]       crc_val,
  output logic              crc_init,
  output logic              crc_en,
  output logic [7:0]        crc_din,
  output logic [7:0]        m_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              busy,
  output logic              done
);
  localparam int PC_W = $clog2(PRE_COUNT + 1);

  frm_state_e        state;
  logic [7:0]        grp_q;
  logic [7:0]        hdr_q;
  logic [7:0]        len_q;
  logic [ADDR_W-1:0] idx;
  logic [PC_W-1:0]   pre_cnt;
  logic              slot;
  logic              ld;
  logic [7:0]        ld_byte;
  logic [ADDR_W-1:0] last_idx;

  assign slot     = !m_valid || m_ready;
  assign last_idx = ADDR_W'(len_q - 8'd1);
  assign busy     = (state != ST_IDLE);
  assign crc_init = (state == ST_IDLE) && start;
  assign cap_we   = (state == ST_CAPT) && s_valid && s_ready;
  assign cap_addr = ADDR_W'(len_q);
  assign crc_din  = ld_byte;

  // Byte selection for the output register and checksum update.
  always_comb begin
    ld      = 1'b0;
    ld_byte = 8'h00;
    crc_en  = 1'b0;
    case (state)
      ST_PRE:  begin ld = slot; ld_byte = PRE_BYTE;       end
      ST_SYNC: begin ld = slot; ld_byte = SYNC_BYTE;      end
      ST_GRP:  begin ld = slot; ld_byte = grp_q;   crc_en = slot; end
      ST_HDR:  begin ld = slot; ld_byte = hdr_q;   crc_en = slot; end
      ST_LEN:  begin ld = slot; ld_byte = len_q;   crc_en = slot; end
      ST_PAY:  begin ld = slot; ld_byte = rd_data; crc_en = slot; end
      ST_CRCL: begin ld = slot; ld_byte = crc_val[7:0];   end
      ST_CRCH: begin ld = slot; ld_byte = crc_val[15:8];  end
      ST_PAD:  begin ld = slot; ld_byte = PAD_BYTE;       end
      default: ;
    endcase
  end

  // Look one byte ahead so the registered read is ready for back-to-back loads.
  assign rd_addr = (state == ST_PAY && slot) ? idx + ADDR_W'(1) : idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      m_valid <= 1'b0;
      m_data  <= 8'h00;
      s_ready <= 1'b0;
      done    <= 1'b0;
      grp_q   <= 8'h00;
      hdr_q   <= 8'h00;
      len_q   <= 8'h00;
      idx     <= '0;
      pre_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (ld) begin
        m_valid <= 1'b1;
        m_data  <= ld_byte;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end

      case (state)
        ST_IDLE: begin
          if (start) begin
            grp_q   <= cfg_group;
            hdr_q   <= cfg_header;
            idx     <= '0;
            pre_cnt <= '0;
            if (!src_buf) begin
              s_ready <= 1'b1;
              len_q   <= 8'h00;
              state   <= ST_CAPT;
            end else if (cfg_len != 8'h00) begin
              len_q <= cfg_len;
              state <= ST_PRE;
            end
          end
        end
        ST_CAPT: begin
          if (s_valid && s_ready) begin
            len_q <= len_q + 8'd1;
            if (s_last || len_q == 8'(MAX_LEN - 1)) begin
              s_ready <= 1'b0;
              state   <= ST_PRE;
            end
          end
        end
        ST_PRE: begin
          if (ld) begin
            pre_cnt <= pre_cnt + PC_W'(1);
            if (pre_cnt == PC_W'(PRE_COUNT - 1)) state <= ST_SYNC;
          end
        end
        ST_SYNC: if (ld) state <= ST_GRP;
        ST_GRP:  if (ld) state <= ST_HDR;
        ST_HDR:  if (ld) state <= ST_LEN;
        ST_LEN:  if (ld) state <= ST_PAY;
        ST_PAY: begin
          if (ld) begin
            idx <= idx + ADDR_W'(1);
            if (idx == last_idx) state <= ST_CRCL;
          end
        end
        ST_CRCL: if (ld) state <= ST_CRCH;
        ST_CRCH: if (ld) state <= ST_PAD;
        ST_PAD:  if (ld) state <= ST_DRAIN;
        ST_DRAIN: begin
          if (m_valid && m_ready) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer #(
  parameter int          MAX_LEN   = 255,
  parameter int          PRE_COUNT = 3,
  parameter logic [7:0]  PRE_BYTE  = 8'hAA,
  parameter logic [7:0]  SYNC_BYTE = 8'h2D,
  parameter logic [7:0]  PAD_BYTE  = 8'hAA,
  parameter logic [15:0] CRC_POLY  = 16'hA001,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF,
  parameter int          ADDR_W    = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              src_buf,
  input  logic [7:0]        cfg_group,
  input  logic [7:0]        cfg_header,
  input  logic [7:0]        cfg_len,
  input  logic              bw_en,
  input  logic [ADDR_W-1:0] bw_addr,
  input  logic [7:0]        bw_data,
  input  logic [7:0]        s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic [7:0]        m_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              busy,
  output logic              done
);
  logic              cap_we;
  logic [ADDR_W-1:0] cap_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;
  logic [15:0]       crc_val;
  logic              crc_init;
  logic              crc_en;
  logic [7:0]        crc_din;

  // Stream capture owns the write port while its window is open.
  assign mem_we    = cap_we | bw_en;
  assign mem_waddr = cap_we ? cap_addr : bw_addr;
  assign mem_wdata = cap_we ? s_data : bw_data;

  pkt_payload_buf #(
    .ADDR_W (ADDR_W),
    .DATA_W (8)
  ) u_buf (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  pkt_crc16 #(
    .POLY (CRC_POLY),
    .INIT (CRC_INIT)
  ) u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (crc_init),
    .en   (crc_en),
    .din  (crc_din),
    .crc  (crc_val)
  );

  pkt_frame_seq #(
    .ADDR_W    (ADDR_W),
    .MAX_LEN   (MAX_LEN),
    .PRE_COUNT (PRE_COUNT),
    .PRE_BYTE  (PRE_BYTE),
    .SYNC_BYTE (SYNC_BYTE),
    .PAD_BYTE  (PAD_BYTE)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .src_buf    (src_buf),
    .cfg_group  (cfg_group),
    .cfg_header (cfg_header),
    .cfg_len    (cfg_len),
    .s_valid    (s_valid),
    .s_last     (s_last),
    .s_ready    (s_ready),
    .cap_we     (cap_we),
    .cap_addr   (cap_addr),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .crc_val    (crc_val),
    .crc_init   (crc_init),
    .crc_en     (crc_en),
    .crc_din    (crc_din),
    .m_data     (m_data),
    .m_valid    (m_valid),
    .m_ready    (m_ready),
    .busy       (busy),
    .done       (done)
  );

endmodule

// File: rtl/pkt_tx_framer_chk.sv
module pkt_tx_framer_chk #(
  parameter logic [7:0] PAD_BYTE = 8'hAA
) (
  input logic       clk,
  input logic       rst,
  input logic [7:0] m_data,
  input logic       m_valid,
  input logic       m_ready,
  input logic       s_ready,
  input logic       busy,
  input logic       done
);

  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_after_pad: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(m_valid && m_ready && (m_data == PAD_BYTE)));

  a_r4_capture_before_send: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> !m_valid);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !m_valid);

endmodule

bind pkt_tx_framer pkt_tx_framer_chk #(.PAD_BYTE(PAD_BYTE)) u_chk (.*);

// File: tb/pkt_tx_framer_tb.sv
module pkt_tx_framer_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       src_buf = 1'b1;
  logic [7:0] cfg_group = 8'h00;
  logic [7:0] cfg_header = 8'h00;
  logic [7:0] cfg_len = 8'h00;
  logic       bw_en = 1'b0;
  logic [7:0] bw_addr = 8'h00;
  logic [7:0] bw_data = 8'h00;
  logic [7:0] s_data = 8'h00;
  logic       s_valid = 1'b0;
  logic       s_last = 1'b0;
  logic       s_ready;
  logic [7:0] m_data;
  logic       m_valid;
  logic       m_ready = 1'b1;
  logic       busy;
  logic       done;

  pkt_tx_framer u_dut (
    .clk(clk), .rst(rst), .start(start), .src_buf(src_buf),
    .cfg_group(cfg_group), .cfg_header(cfg_header), .cfg_len(cfg_len),
    .bw_en(bw_en), .bw_addr(bw_addr), .bw_data(bw_data),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready),
    .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int rdy_mode = 0;
  int cyc = 0;
  int hold_err = 0;
  int hold_seen = 0;
  bit hold_pend = 0;
  logic [7:0] hold_d = 8'h00;
  bit finished = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];

  // mode, len, group, header, seed, ready pattern
  localparam logic [47:0] VEC [6] = '{
    48'h01_04_D4_11_54_00,
    48'h00_01_01_00_00_01,
    48'h01_FF_FF_FF_80_00,
    48'h00_11_2A_9C_03_02,
    48'h01_02_00_00_FF_01,
    48'h00_40_D4_11_11_00
  };

  // Sink ready, driven just after each rising edge.
  always begin
    @(posedge clk);
    #1;
    cyc++;
    case (rdy_mode)
      1:       m_ready = cyc[0];
      2:       m_ready = (cyc % 4) != 0;
      default: m_ready = 1'b1;
    endcase
  end

  // Output monitor at the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (m_valid && m_ready) got_q.push_back(m_data);
      if (done) done_cnt++;
      if (hold_pend) begin
        if (!(m_valid && m_data == hold_d)) hold_err++;
      end
      hold_pend = m_valid && !m_ready;
      if (hold_pend) hold_seen++;
      hold_d = m_data;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end actual=hung expected=finished");
    summary();
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pbyte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) begin
      if (r[0]) r = (r >> 1) ^ 16'hA001;
      else      r = r >> 1;
    end
    return r;
  endfunction

  task automatic build_exp(input logic [7:0] grp, input logic [7:0] hdr,
                           input int len, input logic [7:0] seed);
    logic [15:0] c;
    exp_q.delete();
    c = 16'hFFFF;
    repeat (3) exp_q.push_back(8'hAA);
    exp_q.push_back(8'h2D);
    exp_q.push_back(grp); c = ref_crc(c, grp);
    exp_q.push_back(hdr); c = ref_crc(c, hdr);
    exp_q.push_back(8'(len)); c = ref_crc(c, 8'(len));
    for (int i = 0; i < len; i++) begin
      exp_q.push_back(pbyte(seed, i));
      c = ref_crc(c, pbyte(seed, i));
    end
    exp_q.push_back(c[7:0]);
    exp_q.push_back(c[15:8]);
    exp_q.push_back(8'hAA);
  endtask

  task automatic check_frame(input string req);
    int bad;
    bad = -1;
    if (got_q.size() != exp_q.size()) begin
      chk(0, req, "frame byte count", got_q.size(), exp_q.size());
    end else begin
      for (int i = 0; i < exp_q.size(); i++) begin
        if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
      end
      if (bad >= 0) chk(0, req, $sformatf("frame byte %0d", bad), got_q[bad], exp_q[bad]);
      else          chk(1, req, "frame", 0, 0);
    end
  endtask

  task automatic write_buf(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      bw_en = 1'b1; bw_addr = 8'(i); bw_data = pbyte(seed, i);
    end
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic start_pulse(input bit sb, input logic [7:0] grp,
                             input logic [7:0] hdr, input logic [7:0] len);
    @(negedge clk);
    src_buf = sb; cfg_group = grp; cfg_header = hdr; cfg_len = len;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed_stream(input int n, input logic [7:0] seed,
                             input bit gaps, input bit use_last);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin
        s_valid = 1'b0;
        @(negedge clk);
      end
      s_valid = 1'b1;
      s_data  = pbyte(seed, i);
      s_last  = use_last && (i == n - 1);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
  endtask

  task automatic wait_done(input int maxc);
    int n;
    n = 0;
    while (done_cnt == 0 && n < maxc) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_run();
    got_q.delete();
    done_cnt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs quiet during reset
    chk(!m_valid && !s_ready && !busy && !done, "R11", "reset outputs",
        {m_valid, s_ready, busy, done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!m_valid && !s_ready && !busy && !done, "R11", "after reset",
        {m_valid, s_ready, busy, done}, 0);

    // R9: first-byte latency and one byte per cycle
    begin
      int k;
      int done_k;
      rdy_mode = 0;
      write_buf(3, 8'h21);
      clear_run();
      build_exp(8'h5A, 8'hC3, 3, 8'h21);
      @(negedge clk);
      src_buf = 1'b1; cfg_group = 8'h5A; cfg_header = 8'hC3; cfg_len = 8'd3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!m_valid, "R9", "valid after sampling edge", m_valid, 0);
      @(negedge clk);
      chk(m_valid && m_data == 8'hAA, "R9", "first byte after next edge",
          {m_valid, m_data}, 9'h1AA);
      k = 1;
      done_k = -1;
      while (k < 40 && done_k < 0) begin
        @(negedge clk);
        k++;
        if (done) done_k = k;
      end
      chk(done_k == 14, "R9", "done edge index for length 3", done_k, 14);
      @(negedge clk);
      check_frame("R1 R2 R9");
    end

    // Vector table
    for (int v = 0; v < 6; v++) begin
      logic [47:0] e;
      int len;
      e = VEC[v];
      len = int'(e[39:32]);
      rdy_mode = int'(e[7:0]);
      clear_run();
      build_exp(e[31:24], e[23:16], len, e[15:8]);
      if (e[47:40] == 8'h01) begin
        write_buf(len, e[15:8]);
        clear_run();
        start_pulse(1'b1, e[31:24], e[23:16], e[39:32]);
      end else begin
        start_pulse(1'b0, e[31:24], e[23:16], 8'h00);
        feed_stream(len, e[15:8], rdy_mode != 0, 1'b1);
      end
      wait_done(3000);
      if (e[47:40] == 8'h01) check_frame("R1 R2 R3");
      else                   check_frame("R1 R2 R4");
      chk(done_cnt == 1, "R6", $sformatf("done pulses vector %0d", v), done_cnt, 1);
    end
    rdy_mode = 0;

    // R5: zero-length buffer request
    clear_run();
    start_pulse(1'b1, 8'h12, 8'h34, 8'h00);
    repeat (20) begin
      @(negedge clk);
      if (busy) hold_err += 0;
    end
    chk(got_q.size() == 0 && done_cnt == 0 && !busy, "R5", "zero length silent",
        got_q.size() + done_cnt + int'(busy), 0);

    // R8: configuration changes after the request
    write_buf(8, 8'h40);
    clear_run();
    build_exp(8'h55, 8'hA5, 8, 8'h40);
    start_pulse(1'b1, 8'h55, 8'hA5, 8'd8);
    repeat (4) @(negedge clk);
    cfg_group = 8'h66; cfg_header = 8'h77; cfg_len = 8'd2;
    wait_done(500);
    check_frame("R8");

    // R10: start while busy
    rdy_mode = 1;
    clear_run();
    build_exp(8'h19, 8'h91, 8, 8'h40);
    start_pulse(1'b1, 8'h19, 8'h91, 8'd8);
    repeat (5) @(negedge clk);
    src_buf = 1'b0; cfg_group = 8'hEE; cfg_header = 8'hDD;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!s_ready, "R10", "no capture window from ignored start", s_ready, 0);
    wait_done(500);
    repeat (30) @(negedge clk);
    check_frame("R10");
    chk(done_cnt == 1, "R10", "single done", done_cnt, 1);
    rdy_mode = 0;

    // R4: capture limit without a last flag
    clear_run();
    build_exp(8'h0F, 8'hF0, 255, 8'h09);
    start_pulse(1'b0, 8'h0F, 8'hF0, 8'h00);
    feed_stream(255, 8'h09, 1'b0, 1'b0);
    chk(!s_ready, "R4", "window closed after 255 beats", s_ready, 0);
    s_valid = 1'b1; s_data = 8'h00;
    repeat (3) @(negedge clk);
    s_valid = 1'b0;
    wait_done(1000);
    check_frame("R4");

    // R7: stalls seen and held
    chk(hold_seen > 0 && hold_err == 0, "R7", "stall hold violations",
        hold_err, 0);

    summary();
  end

endmodule